// File: doc/BRIEF.md
# OSD Character Shadow Generator

This block classifies each pixel of an on-screen-display character as background, foreground or shadow. Every cycle it receives a 3x3 window of foreground bits centred on the current pixel. The window is built upstream from the glyph rows. The block decides whether the centre pixel should carry a drop shadow. An apparent light source sits at one of seven compass positions, or the block draws an outline on every side of the glyph. The shadow falls on the side of the glyph that faces away from the light.

The shadow style is held in a small state machine. The machine loads a new style only when the frame-start strobe is high, so a field is never drawn with a mix of styles. Its states are `ST_OFF`, `ST_SW`, `ST_W`, `ST_NW`, `ST_N`, `ST_NE`, `ST_E`, `ST_SE` and `ST_ALL`.

Every state has one transition, taken on a clock edge with `frame_start` high. If `shd_en` is 0 the machine goes to `ST_OFF`. If `shd_en` is 1 it goes to the state that `shd_dir` selects. With `frame_start` low, every state holds.

The pixel class is registered and appears one cycle after its window. A delayed valid flag travels with it.

Top module: `osd_shadow_gen`

## Requirements
- R1: The window bit for row r and column c is `pix_win[3*r+c]`, where row 0 is the top (north) and column 0 is the left (west). The centre pixel is bit 4.
- R1: `out_cls` is encoded as 00 for background, 01 for foreground and 10 for shadow. The value 11 never appears.
- R1: The class for the inputs of cycle n appears on `out_cls` after the clock edge that ends cycle n.
- R2: While the latched style is off, no pixel is classed as shadow. The style is off when `shd_en` was 0 at the last strobe, whatever `shd_dir` held.
- R3: With enable at 1, `shd_dir` codes 0 to 6 select the light-source neighbour that the centre pixel tests. The codes and the window bits they test are:
  - 0 = south-west, bit 6
  - 1 = west, bit 3
  - 2 = north-west, bit 0
  - 3 = north, bit 1
  - 4 = north-east, bit 2
  - 5 = east, bit 5
  - 6 = south-east, bit 8
- R3: A non-foreground pixel is shadow exactly when that one neighbour bit is 1.
- R4: With enable at 1, code 7 selects outline mode. In this mode a non-foreground pixel is shadow when any of its eight neighbours is 1.
- R5: A valid pixel whose centre bit is 1 is always classed as foreground, whatever the neighbours or the style.
- R6: `out_vld` equals `pix_vld` delayed by one cycle.
- R6: When `pix_vld` is 0, the next `out_cls` is background.
- R7: `shd_en` and `shd_dir` take effect only at a clock edge where `frame_start` is 1. Changes to them at any other time have no effect on the output.
- R7: The pixel presented in the strobe cycle still uses the previous style. The new style applies from the next cycle.
- R8: After reset, `out_vld` is 0, `out_cls` is background, and the style is off until the first strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Strobe that loads the shadow style |
| shd_en | input | 1 | Shadow enable, sampled at the strobe |
| shd_dir | input | 3 | Light-source code, sampled at the strobe |
| pix_vld | input | 1 | Window-valid qualifier |
| pix_win | input | 9 | 3x3 foreground window, row-major from north-west |
| out_vld | output | 1 | Delayed valid |
| out_cls | output | 2 | Pixel class |

## Verification
The style register is the only lasting state in the block. If that state is wrong, the error shows within one cycle of the first valid pixel that has a set neighbour. The shadow then appears on the wrong side, or appears when it should be absent, or is missing from an outline. A style that leaks through without a strobe shows on the next pixel after the inputs change in mid-frame. The bench therefore probes every direction with single-neighbour windows. It also changes the mode between strobes and checks the pixel in the strobe cycle itself.

// File: rtl/osd_shadow_pkg.sv
package osd_shadow_pkg;
    localparam int WIN_SIDE = 3;
    localparam int WIN_BITS = WIN_SIDE * WIN_SIDE;
    localparam int CTR_IDX  = WIN_BITS / 2;
    localparam int NBR_CNT  = WIN_BITS - 1;
    localparam int DIR_W    = 3;
    localparam int CLS_W    = 2;

    typedef enum logic [CLS_W-1:0] {
        PX_BG  = 2'b00,
        PX_FG  = 2'b01,
        PX_SHD = 2'b10
    } pix_cls_e;

    typedef enum logic [3:0] {
        ST_OFF = 4'd0,
        ST_SW  = 4'd1,
        ST_W   = 4'd2,
        ST_NW  = 4'd3,
        ST_N   = 4'd4,
        ST_NE  = 4'd5,
        ST_E   = 4'd6,
        ST_SE  = 4'd7,
        ST_ALL = 4'd8
    } style_e;

    function automatic int nbr_bit(int dr, int dc);
        return (1 + dr) * WIN_SIDE + (1 + dc);
    endfunction
endpackage

// File: rtl/osd_shadow_style.sv
module osd_shadow_style
    import osd_shadow_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             shd_en,
    input  logic [DIR_W-1:0] shd_dir,
    output style_e           style_q
);
    style_e style_d;

    always_comb begin
        style_d = style_q;
        if (frame_start) begin
            if (!shd_en) begin
                style_d = ST_OFF;
            end else begin
                unique case (shd_dir)
                    3'd0: style_d = ST_SW;
                    3'd1: style_d = ST_W;
                    3'd2: style_d = ST_NW;
                    3'd3: style_d = ST_N;
                    3'd4: style_d = ST_NE;
                    3'd5: style_d = ST_E;
                    3'd6: style_d = ST_SE;
                    3'd7: style_d = ST_ALL;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            style_q <= ST_OFF;
        end else begin
            style_q <= style_d;
        end
    end
endmodule

// File: rtl/osd_shadow_nbr.sv
module osd_shadow_nbr
    import osd_shadow_pkg::*;
(
    input  style_e                style_q,
    input  logic [WIN_BITS-1:0]   win,
    output logic                  hit
);
    // Clockwise ring of neighbours starting at south-west; index k matches
    // the directional state whose encoding is k+1.
    localparam int RING_DR [NBR_CNT] = '{ 1,  0, -1, -1, -1,  0,  1,  1};
    localparam int RING_DC [NBR_CNT] = '{-1, -1, -1,  0,  1,  1,  1,  0};

    logic [NBR_CNT-1:0] ring;

    for (genvar k = 0; k < NBR_CNT; k++) begin : g_ring
        assign ring[k] = win[nbr_bit(RING_DR[k], RING_DC[k])];
    end

    logic [DIR_W-1:0] ring_sel;
    assign ring_sel = DIR_W'(style_q - 4'd1);

    always_comb begin
        unique case (style_q)
            ST_OFF:  hit = 1'b0;
            ST_ALL:  hit = |ring;
            default: hit = ring[ring_sel];
        endcase
    end
endmodule

// File: rtl/osd_shadow_gen.sv
module osd_shadow_gen
    import osd_shadow_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                shd_en,
    input  logic [2:0]          shd_dir,
    input  logic                pix_vld,
    input  logic [8:0]          pix_win,
    output logic                out_vld,
    output logic [1:0]          out_cls
);
    style_e style_q;
    logic   shd_hit;

    osd_shadow_style u_style (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .shd_en      (shd_en),
        .shd_dir     (shd_dir),
        .style_q     (style_q)
    );

    osd_shadow_nbr u_nbr (
        .style_q (style_q),
        .win     (pix_win),
        .hit     (shd_hit)
    );

    pix_cls_e cls_d;

    always_comb begin
        if (!pix_vld) begin
            cls_d = PX_BG;
        end else if (pix_win[CTR_IDX]) begin
            cls_d = PX_FG;
        end else if (shd_hit) begin
            cls_d = PX_SHD;
        end else begin
            cls_d = PX_BG;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_cls <= PX_BG;
        end else begin
            out_vld <= pix_vld;
            out_cls <= cls_d;
        end
    end
endmodule

// File: rtl/osd_shadow_chk.sv
module osd_shadow_chk
    import osd_shadow_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       frame_start,
    input logic       pix_vld,
    input logic [8:0] pix_win,
    input logic       out_vld,
    input logic [1:0] out_cls,
    input style_e     style_q
);
    a_r1_cls_legal: assert property (@(posedge clk) disable iff (!rst_n)
        out_cls != 2'b11);

    a_r2_off_no_shadow: assert property (@(posedge clk) disable iff (!rst_n)
        (style_q == ST_OFF) |=> (out_cls != PX_SHD));

    a_r4_empty_is_bg: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && pix_win == '0) |=> (out_cls == PX_BG));

    a_r5_fg_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld && pix_win[CTR_IDX]) |=> (out_cls == PX_FG));

    a_r6_vld_delay: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld |=> out_vld);

    a_r6_idle_bg: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_vld |=> (!out_vld && out_cls == PX_BG));

    a_r7_style_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(style_q));
endmodule

bind osd_shadow_gen osd_shadow_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .pix_vld     (pix_vld),
    .pix_win     (pix_win),
    .out_vld     (out_vld),
    .out_cls     (out_cls),
    .style_q     (style_q)
);

// File: tb/osd_shadow_gen_tb.sv
module osd_shadow_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       shd_en = 1'b0;
    logic [2:0] shd_dir = 3'd0;
    logic       pix_vld = 1'b0;
    logic [8:0] pix_win = 9'd0;
    logic       out_vld;
    logic [1:0] out_cls;

    int checks = 0;
    int errors = 0;
    int ref_style = -1;          // -1 off, 0..6 directional, 7 outline
    int exp_cls[$];
    int exp_vld[$];
    string exp_tag[$];

    always #4 clk = ~clk;

    osd_shadow_gen dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .shd_en(shd_en), .shd_dir(shd_dir), .pix_vld(pix_vld),
        .pix_win(pix_win), .out_vld(out_vld), .out_cls(out_cls)
    );

    function automatic int model_cls(int sty, bit vld, logic [8:0] w);
        int dr[7] = '{ 1,  0, -1, -1, -1, 0, 1};
        int dc[7] = '{-1, -1, -1,  0,  1, 1, 1};
        if (!vld) return 0;
        if (w[4]) return 1;
        if (sty < 0) return 0;
        if (sty == 7) begin
            for (int r = 0; r < 3; r++)
                for (int c = 0; c < 3; c++)
                    if (!(r == 1 && c == 1) && w[r*3+c]) return 2;
            return 0;
        end
        return w[(1+dr[sty])*3 + (1+dc[sty])] ? 2 : 0;
    endfunction

    task automatic compare_one();
        int ec, ev;
        string t;
        if (exp_cls.size() == 0) return;
        ec = exp_cls.pop_front();
        ev = exp_vld.pop_front();
        t  = exp_tag.pop_front();
        checks++;
        if (int'(out_cls) != ec || int'(out_vld) != ev) begin
            errors++;
            $display("FAIL %s: cls=%0d vld=%0d expected cls=%0d vld=%0d",
                     t, out_cls, out_vld, ec, ev);
        end
    endtask

    task automatic step(bit fs, bit en, logic [2:0] dir, bit vld,
                        logic [8:0] w, string tag);
        string t;
        int c;
        @(negedge clk);
        compare_one();
        frame_start = fs; shd_en = en; shd_dir = dir;
        pix_vld = vld; pix_win = w;
        c = model_cls(ref_style, vld, w);
        if (tag != "") t = tag;
        else if (!vld) t = "R6";
        else if (w[4]) t = "R5";
        else if (ref_style < 0) t = "R2";
        else if (ref_style == 7) t = "R4";
        else t = "R3";
        exp_cls.push_back(c);
        exp_vld.push_back(int'(vld));
        exp_tag.push_back(t);
        if (fs) ref_style = en ? int'(dir) : -1;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;   // R8 reset state
        if (out_vld !== 1'b0 || out_cls !== 2'b00) begin
            errors++;
            $display("FAIL R8: cls=%0d vld=%0d expected cls=0 vld=0", out_cls, out_vld);
        end
        rst_n = 1'b1;
        // R8: style off after reset even with neighbours lit and inputs set
        step(0, 1, 3'd7, 1, 9'b111_101_111, "R8");
        step(0, 1, 3'd0, 1, 9'b001_000_000, "R8");
        // R1: latency and encoding, single foreground then empty
        step(0, 0, 3'd0, 1, 9'b000_010_000, "R1");
        step(0, 0, 3'd0, 1, 9'b000_000_000, "R1");
        // Walk every style including disabled-with-outline-code
        for (int s = 0; s < 9; s++) begin
            bit en = (s < 8);
            logic [2:0] d = (s < 8) ? 3'(s) : 3'd7;
            step(1, en, d, 0, 9'd0, "");
            for (int b = 0; b < 9; b++)
                step(0, 0, 3'd0, 1, 9'(1 << b), "");
            for (int i = 0; i < 24; i++)
                step(0, ~en, 3'($urandom), ($urandom % 4) != 0, 9'($urandom), "");
        end
        // R7: strobe-cycle pixel uses old style (off), then SW applies
        step(1, 1, 3'd0, 1, 9'b001_000_000, "R7");
        step(0, 1, 3'd0, 1, 9'b001_000_000, "R7");
        // R7: mid-frame change to east is ignored
        step(0, 1, 3'd5, 1, 9'b000_001_000, "R7");
        step(0, 0, 3'd5, 1, 9'b001_000_000, "R7");
        // R7: strobe to outline; strobe pixel still south-west
        step(1, 1, 3'd7, 1, 9'b000_001_000, "R7");
        step(0, 0, 3'd1, 1, 9'b000_001_000, "R7");
        // R2: disable while mode says outline
        step(1, 0, 3'd7, 1, 9'b000_000_000, "R2");
        step(0, 1, 3'd7, 1, 9'b111_101_111, "R2");
        step(0, 0, 3'd0, 0, 9'd0, "R6");
        step(0, 0, 3'd0, 0, 9'd0, "R6");
        @(negedge clk);
        compare_one();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule